// File: doc/BRIEF.md
# Sleep Interrupt Capture and Replay

This block sits between a group of external interrupt lines and a parent interrupt controller that may be switched off. Each line is synchronized and watched for the event that its programmed trigger describes. An event can be an edge or a level, of either polarity. Every event seen on an unmasked line sets a bit in a status bank. Recording goes on whether or not the block is enabled. While the block is disabled, the parent receives the raw lines unchanged. While it is enabled, the parent lines are held quiet.

Before the parent is powered down, software clears stale status bits and enables the block. It may also select an edge-only recording mode, which ignores level-triggered lines. Once the parent is awake again, software issues a flush command. The flush re-emits every recorded, unmasked event as a single-cycle pulse on the parent line and clears those status bits as they are sent.

Software configures the block through a word-addressed register port. Per-line settings are changed through separate write-one-to-set and write-one-to-clear addresses. A parameter selects between two register address layouts.

Top module: `slp_irq_recorder`

## Requirements
- R1: Line n of a per-line bank is at byte address bank_base + (n/32)*4, in bit n%32. With LAYOUT=0 the bank bases are: status 0x000, acknowledge 0x040, mask set 0x0C0, mask clear 0x100, sense set 0x180, sense clear 0x1C0, polarity set 0x240, polarity clear 0x280, control 0x300. With LAYOUT=1 every base is doubled, so control sits at 0x600 and polarity set at 0x480. Addresses outside these ranges read 0.
- R2: A write of 1 to a bit at a set address sets only that configuration bit, and a write of 1 at a clear address clears only that bit. Bits written as 0 leave the register unchanged. A read at either the set or the clear address returns the current register value.
- R3: After reset, mask is all 0 (unmasked), sense is all 0 (edge), polarity is all 1, status is 0 and control reads 0.
- R4: Sense bit 0 selects edge triggering and sense bit 1 selects level triggering. Polarity bit 1 selects a rising edge or a high level; polarity bit 0 selects a falling edge or a low level. An event sets the line's status bit within 4 cycles of the input change, whether the enable bit is set or not.
- R5: A line whose mask bit is 1 records no events.
- R6: A write of 1 to a bit of the acknowledge bank clears only the matching status bit.
- R7: When control bit 1 (edge-only) is set, lines with sense bit 1 record nothing; lines with sense bit 0 record as usual.
- R8: With control bit 0 (enable) clear, irq_out follows irq_in with no register delay. With enable set, irq_out is 0 except during replay pulses.
- R9: A write with control bit 2 (flush) set causes a one-cycle pulse on irq_out, in the cycle after the write, for every recorded status bit of an unmasked line. Those status bits clear at the same time, and the flush bit then reads 0. Recorded bits of masked lines are neither pulsed nor cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N | External interrupt lines |
| irq_out | output | N | Lines to the parent controller (pass-through or replay pulses) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
On every cycle, the assertions check four things:
- new status bits never appear on a masked line, and never on a level line while edge-only mode is on;
- replay pulses come only from bits that were recorded, and only in the cycle after a pending flush;
- the flush bit clears itself;
- irq_out follows irq_in when the block is disabled and stays quiet when it is enabled.

The bench scenarios cover what a single-cycle property cannot. These are the trigger and polarity combinations, including edges in the wrong direction that must not record, and the address arithmetic across both words and both layouts. They also cover the exact timing and content of a flush pulse, and the set, clear and acknowledge behaviour seen through register reads.

// File: rtl/slp_irq_pkg.sv
package slp_irq_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    typedef enum logic [3:0] {
        BK_STAT, BK_ACK, BK_MSET, BK_MCLR, BK_SSET,
        BK_SCLR, BK_PSET, BK_PCLR, BK_CTRL, BK_NONE
    } bank_e;

    localparam int NUM_BANKS = 9;
    localparam int CTRL_FLUSH = 2;

    // Control word: bit 0 enable, bit 1 edge-only, bit 2 flush
    typedef struct packed {
        logic flush;
        logic edge_only;
        logic en;
    } ctrl_t;

    function automatic logic [ADDR_W-1:0] bank_base(input int layout, input bank_e b);
        logic [ADDR_W-1:0] v;
        case (b)
            BK_STAT: v = 12'h000;
            BK_ACK:  v = 12'h040;
            BK_MSET: v = 12'h0C0;
            BK_MCLR: v = 12'h100;
            BK_SSET: v = 12'h180;
            BK_SCLR: v = 12'h1C0;
            BK_PSET: v = 12'h240;
            BK_PCLR: v = 12'h280;
            BK_CTRL: v = 12'h300;
            default: v = 12'h000;
        endcase
        return (layout == 1) ? {v[ADDR_W-2:0], 1'b0} : v;
    endfunction

    function automatic logic [ADDR_W-1:0] bank_span(input int nwords, input bank_e b);
        if (b == BK_CTRL) return 12'd4;
        return ADDR_W'(nwords * 4);
    endfunction

endpackage

// File: rtl/slp_irq_sync.sv
module slp_irq_sync #(
    parameter int N = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] irq_in,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= irq_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl  = sync_q;
    assign rise = sync_q & ~prev_q;
    assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/slp_irq_regdec.sv
module slp_irq_regdec
    import slp_irq_pkg::*;
#(
    parameter int N      = 48,
    parameter int LAYOUT = 0,
    parameter int NWORDS = (N + 31) / 32,
    parameter int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output bank_e             bank,
    output logic [WIDX_W-1:0] widx,
    output logic [N-1:0]      line_bits
);
    always_comb begin
        bank = BK_NONE;
        widx = '0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            logic [ADDR_W-1:0] base;
            logic [ADDR_W-1:0] off;
            base = bank_base(LAYOUT, bank_e'(k));
            off  = addr - base;
            if (addr >= base && off < bank_span(NWORDS, bank_e'(k)) && addr[1:0] == 2'b00) begin
                bank = bank_e'(k);
                widx = off[WIDX_W+1:2];
            end
        end
    end

    // Map the written word onto the lines it covers
    for (genvar i = 0; i < N; i++) begin : g_line
        assign line_bits[i] = (widx == WIDX_W'(i / 32)) & wdata[i % 32];
    end
endmodule

// File: rtl/slp_irq_capture.sv
module slp_irq_capture #(
    parameter int N = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] rise,
    input  logic [N-1:0] fall,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] sens,
    input  logic [N-1:0] pol,
    input  logic         edge_only,
    input  logic [N-1:0] ack,
    input  logic         flush_go,
    output logic [N-1:0] status,
    output logic [N-1:0] replay
);
    logic [N-1:0] hit, take;

    for (genvar i = 0; i < N; i++) begin : g_det
        logic edge_hit, lvl_hit;
        assign edge_hit = pol[i] ? rise[i] : fall[i];
        assign lvl_hit  = (lvl[i] == pol[i]);
        assign hit[i]   = ~mask[i] & (sens[i] ? (~edge_only & lvl_hit) : edge_hit);
    end

    assign take = flush_go ? (status & ~mask) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            replay <= '0;
        end else begin
            replay <= take;
            status <= (status & ~ack & ~take) | hit;
        end
    end
endmodule

// File: rtl/slp_irq_recorder.sv
module slp_irq_recorder
    import slp_irq_pkg::*;
#(
    parameter int N      = 48,
    parameter int LAYOUT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      irq_in,
    output logic [N-1:0]      irq_out,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int NWORDS = (N + 31) / 32;
    localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int NPAD   = NWORDS * 32;

    bank_e             bank;
    logic [WIDX_W-1:0] widx;
    logic [N-1:0]      wbits, ack_bits;
    logic [N-1:0]      mask_q, sens_q, pol_q;
    logic [N-1:0]      lvl, rise, fall, status_q, replay_q;
    ctrl_t             ctrl_q;
    logic              ctrl_wr;

    slp_irq_regdec #(.N(N), .LAYOUT(LAYOUT), .NWORDS(NWORDS), .WIDX_W(WIDX_W)) u_dec (
        .addr(reg_addr), .wdata(reg_wdata), .bank(bank), .widx(widx), .line_bits(wbits)
    );

    slp_irq_sync #(.N(N)) u_sync (
        .clk(clk), .rst(rst), .irq_in(irq_in), .lvl(lvl), .rise(rise), .fall(fall)
    );

    assign ack_bits = (reg_we && bank == BK_ACK) ? wbits : '0;
    assign ctrl_wr  = reg_we && bank == BK_CTRL;

    slp_irq_capture #(.N(N)) u_cap (
        .clk(clk), .rst(rst), .lvl(lvl), .rise(rise), .fall(fall),
        .mask(mask_q), .sens(sens_q), .pol(pol_q), .edge_only(ctrl_q.edge_only),
        .ack(ack_bits), .flush_go(ctrl_q.flush), .status(status_q), .replay(replay_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            sens_q <= '0;
            pol_q  <= '1;
            ctrl_q <= '0;
        end else begin
            ctrl_q.flush <= 1'b0;
            if (reg_we) begin
                case (bank)
                    BK_MSET: mask_q <= mask_q | wbits;
                    BK_MCLR: mask_q <= mask_q & ~wbits;
                    BK_SSET: sens_q <= sens_q | wbits;
                    BK_SCLR: sens_q <= sens_q & ~wbits;
                    BK_PSET: pol_q  <= pol_q | wbits;
                    BK_PCLR: pol_q  <= pol_q & ~wbits;
                    BK_CTRL: ctrl_q <= ctrl_t'(reg_wdata[2:0]);
                    default: ;
                endcase
            end
        end
    end

    assign irq_out = (ctrl_q.en ? '0 : irq_in) | replay_q;

    // Word views of the per-line registers for reads
    logic [NPAD-1:0]   pad_stat, pad_mask, pad_sens, pad_pol;
    logic [DATA_W-1:0] stat_w [NWORDS];
    logic [DATA_W-1:0] mask_w [NWORDS];
    logic [DATA_W-1:0] sens_w [NWORDS];
    logic [DATA_W-1:0] pol_w  [NWORDS];

    assign pad_stat = NPAD'(status_q);
    assign pad_mask = NPAD'(mask_q);
    assign pad_sens = NPAD'(sens_q);
    assign pad_pol  = NPAD'(pol_q);

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        assign stat_w[w] = pad_stat[w*32 +: 32];
        assign mask_w[w] = pad_mask[w*32 +: 32];
        assign sens_w[w] = pad_sens[w*32 +: 32];
        assign pol_w[w]  = pad_pol[w*32 +: 32];
    end

    always_comb begin
        case (bank)
            BK_STAT:          reg_rdata = stat_w[widx];
            BK_MSET, BK_MCLR: reg_rdata = mask_w[widx];
            BK_SSET, BK_SCLR: reg_rdata = sens_w[widx];
            BK_PSET, BK_PCLR: reg_rdata = pol_w[widx];
            BK_CTRL:          reg_rdata = {29'b0, ctrl_q};
            default:          reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/slp_irq_checker.sv
module slp_irq_checker #(
    parameter int N = 48
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         edge_only,
    input logic         flush_pend,
    input logic         flush_req,
    input logic [N-1:0] mask,
    input logic [N-1:0] sens,
    input logic [N-1:0] status,
    input logic [N-1:0] replay,
    input logic [N-1:0] irq_in,
    input logic [N-1:0] irq_out
);
    assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        ((status & ~$past(status)) & $past(mask)) == '0);

    assert_edge_only_R7: assert property (@(posedge clk) disable iff (rst)
        $past(edge_only) |-> (((status & ~$past(status)) & $past(sens)) == '0));

    assert_passthru_R8: assert property (@(posedge clk) disable iff (rst)
        !en |-> (((irq_out ^ irq_in) & ~replay) == '0));

    assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        en |-> ((irq_out & ~replay) == '0));

    assert_flush_selfclear_R9: assert property (@(posedge clk) disable iff (rst)
        (flush_pend && !flush_req) |=> !flush_pend);

    assert_replay_after_flush_R9: assert property (@(posedge clk) disable iff (rst)
        (|replay) |-> $past(flush_pend));

    assert_replay_recorded_R9: assert property (@(posedge clk) disable iff (rst)
        (replay & ~$past(status)) == '0);
endmodule

bind slp_irq_recorder slp_irq_checker #(.N(N)) u_chk (
    .clk(clk), .rst(rst), .en(ctrl_q.en), .edge_only(ctrl_q.edge_only),
    .flush_pend(ctrl_q.flush), .flush_req(ctrl_wr && reg_wdata[CTRL_FLUSH]),
    .mask(mask_q), .sens(sens_q), .status(status_q), .replay(replay_q),
    .irq_in(irq_in), .irq_out(irq_out)
);

// File: tb/test_slp_irq_recorder.sv
module test_slp_irq_recorder;
    localparam int N = 48;
    localparam logic [11:0] A_STAT = 12'h000, A_ACK = 12'h040, A_MSET = 12'h0C0,
                            A_MCLR = 12'h100, A_SSET = 12'h180, A_SCLR = 12'h1C0,
                            A_PSET = 12'h240, A_PCLR = 12'h280, A_CTRL = 12'h300;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_in = '0;
    logic [N-1:0]  irq_out, irq_out_alt;
    logic          we = 1'b0;
    logic [11:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata, rdata_alt;
    int            n_chk = 0;
    int            n_bad = 0;

    always #4 clk = ~clk;

    slp_irq_recorder #(.N(N), .LAYOUT(0)) i_slp_irq_recorder (
        .clk(clk), .rst(rst), .irq_in(irq_in), .irq_out(irq_out),
        .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata));

    slp_irq_recorder #(.N(N), .LAYOUT(1)) i_slp_irq_recorder_alt (
        .clk(clk), .rst(rst), .irq_in(irq_in), .irq_out(irq_out_alt),
        .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata_alt));

    // {line[5:0], sense, polarity, start level, final level, expected status}
    localparam logic [10:0] VEC [9] = '{
        {6'd3,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        {6'd3,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {6'd40, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {6'd40, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {6'd5,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        {6'd5,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {6'd45, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        {6'd45, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {6'd33, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}
    };

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        irq_in = '0;
        rst = 1'b1;
        waitc(3);
        rst = 1'b0;
        waitc(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (R1..R9 run): actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        do_reset();

        // Reset values (R3), read through both set and clear addresses (R2)
        rd(A_STAT, d);     check("R3 status w0", d, 32'h0);
        rd(A_STAT + 4, d); check("R3 status w1", d, 32'h0);
        rd(A_CTRL, d);     check("R3 control", d, 32'h0);
        rd(A_MSET, d);     check("R3 mask", d, 32'h0);
        rd(A_SCLR + 4, d); check("R3 sense w1", d, 32'h0);
        rd(A_PCLR, d);     check("R3 polarity w0", d, 32'hFFFF_FFFF);
        rd(A_PSET + 4, d); check("R3 polarity w1", d, 32'h0000_FFFF);

        // Trigger table (R4): recording while disabled
        for (int k = 0; k < 9; k++) begin
            logic [10:0] v;
            int ln;
            logic [11:0] wo;
            logic [31:0] m;
            v  = VEC[k];
            ln = int'(v[10:5]);
            wo = 12'((ln / 32) * 4);
            m  = 32'h1 << (ln % 32);
            wr((v[4] ? A_SSET : A_SCLR) + wo, m);
            wr((v[3] ? A_PSET : A_PCLR) + wo, m);
            irq_in[ln] = v[2];
            waitc(6);
            wr(A_ACK, 32'hFFFF_FFFF);
            wr(A_ACK + 4, 32'hFFFF_FFFF);
            irq_in[ln] = v[1];
            waitc(6);
            rd(A_STAT + wo, d);
            check($sformatf("R4 vector %0d line %0d", k, ln), {31'b0, d[ln % 32]}, {31'b0, v[0]});
        end

        do_reset();
        // R2 set/clear semantics
        wr(A_MSET, 32'h5);
        wr(A_MCLR, 32'h1);
        rd(A_MSET, d); check("R2 mask set/clear", d, 32'h4);
        wr(A_MSET, 32'h0);
        rd(A_MCLR, d); check("R2 zero write no effect", d, 32'h4);
        wr(A_MCLR, 32'h4);
        // R1 word offset
        wr(A_SSET + 4, 32'h100);
        rd(A_SSET, d);     check("R1 line 40 not in word 0", d, 32'h0);
        rd(A_SSET + 4, d); check("R1 line 40 at word 1 bit 8", d, 32'h100);
        wr(A_SCLR + 4, 32'h100);

        // R8 pass-through while disabled
        irq_in = 48'h8000_0000_0001;
        #1;
        check("R8 pass-through low", irq_out[31:0], 32'h1);
        check("R8 pass-through high", {16'h0, irq_out[47:32]}, 32'h8000);
        irq_in = '0;
        waitc(6);
        wr(A_ACK, 32'hFFFF_FFFF);
        wr(A_ACK + 4, 32'hFFFF_FFFF);

        // R8 quiet while enabled; R4 recording while enabled
        wr(A_CTRL, 32'h1);
        irq_in = 48'h110;
        #1;
        check("R8 enabled output quiet", irq_out[31:0], 32'h0);
        waitc(6);
        rd(A_STAT, d); check("R4 recorded lines 4,8", d, 32'h110);

        // R9 flush
        wr(A_CTRL, 32'h5);
        check("R9 no pulse before replay cycle", irq_out[31:0], 32'h0);
        @(negedge clk);
        check("R9 replay pulse", irq_out[31:0], 32'h110);
        @(negedge clk);
        check("R9 pulse is one cycle", irq_out[31:0], 32'h0);
        rd(A_STAT, d); check("R9 status cleared", d, 32'h0);
        rd(A_CTRL, d); check("R9 flush self-clears", d, 32'h1);

        // R5 masked line not recorded
        wr(A_MSET, 32'h80);
        irq_in[7] = 1'b1;
        irq_in[9] = 1'b1;
        waitc(6);
        rd(A_STAT, d); check("R5 masked line 7 not recorded", d, 32'h200);
        // R9 masked recorded bit neither replayed nor cleared
        wr(A_MSET, 32'h200);
        wr(A_CTRL, 32'h5);
        @(negedge clk);
        check("R9 masked line not replayed", irq_out[31:0], 32'h0);
        rd(A_STAT, d); check("R9 masked bit kept", d, 32'h200);
        wr(A_MCLR, 32'h280);

        // R6 acknowledge
        irq_in[10] = 1'b1;
        waitc(6);
        rd(A_STAT, d); check("R6 before ack", d, 32'h600);
        wr(A_ACK, 32'h200);
        rd(A_STAT, d); check("R6 ack clears one bit", d, 32'h400);
        wr(A_ACK, 32'h400);
        rd(A_STAT, d); check("R6 ack clears last bit", d, 32'h0);

        // R7 edge-only mode
        wr(A_CTRL, 32'h3);
        wr(A_SSET, 32'h1000);
        irq_in[12] = 1'b1;
        irq_in[13] = 1'b1;
        waitc(6);
        rd(A_STAT, d); check("R7 level line ignored", d, 32'h2000);
        wr(A_CTRL, 32'h1);
        waitc(3);
        rd(A_STAT, d); check("R7 level line records after exit", d, 32'h3000);

        // R1 second layout
        do_reset();
        wr(12'h600, 32'h3);
        addr = 12'h600; #1;
        check("R1 layout1 control", rdata_alt, 32'h3);
        check("R1 layout0 unmapped 0x600", rdata, 32'h0);
        addr = 12'h480; #1;
        check("R1 layout1 polarity w0", rdata_alt, 32'hFFFF_FFFF);
        addr = 12'h484; #1;
        check("R1 layout1 polarity w1", rdata_alt, 32'h0000_FFFF);

        summary();
        $finish;
    end
endmodule